// File: doc/BRIEF.md
# Configuration Stream Packet Processor

This block takes a byte-wide configuration stream, one byte per cycle when `in_vld` is high, and hunts through it for the 32-bit alignment marker 0xAA995566 at any byte offset. Until that marker has been seen, every byte is only shifted through the search window and has no other effect. From the byte after the marker onward, bytes are grouped four at a time, most significant byte first, into 32-bit words. Each word is either a packet header or a data word that belongs to the header before it.

Two header kinds are decoded. The short kind names a target register and carries an 11-bit word count. The long kind has no address field. It carries a 27-bit count and writes to the register named by the most recent short header. Five register addresses are decoded: a command register, a frame pointer, a frame data port, an identity register and a checksum register. Frame data words are issued on a write port to an external frame memory. Each frame starts at the frame pointer times the frame length, and the pointer steps forward after every full frame. Frame writes are only issued after the identity register has been written with the expected device identity. The block keeps a running CRC-32C over every data word written. When the checksum register is written, the written value is compared with the running value.

Top module: `cfg_packet_engine`

## Requirements
- R1: No byte affects any register or output other than `synced` until the sequence AA, 99, 55, 66 has arrived on four consecutive accepted bytes. The sequence may start at any byte offset. `synced` then goes high and stays high until reset.
- R2: After the marker, every four accepted bytes form one word, the first byte in bits [31:24]. Word boundaries are counted from the byte after the marker.
- R3: A header with bits [31:29]=001 is a short header. Its opcode is in [28:27] (00 no-op, 01 read, 10 write), its register address in [17:13] and its word count in [10:0]. A write with count N routes the next N words to that address. A count of 0 makes the next word a header.
- R4: A header with bits [31:29]=010 is a long header with a count in [26:0]. A write routes that many words to the address of the most recent short header. If no short header has arrived since reset, the words go to no register, but they are still consumed.
- R5: The decoded addresses are checksum 0, frame pointer 1, frame data 2, command 4 and identity 12. A write to any other address leaves the command, the frame pointer and the frame port unchanged.
- R6: A frame data word is written at address `pointer*FRAME_WORDS + index`. The index starts at 0 when the pointer is written. After FRAME_WORDS words the index returns to 0 and the pointer increments.
- R7: A frame data word is issued only if the most recent identity write equalled DEV_ID; after reset it is dropped. An identity write that does not match sets `id_mismatch`. A matching write clears it.
- R8: Each data word written to an address other than 0 updates the running CRC-32C (reflected polynomial 0x82F63B78, no final inversion, starts at 0 after reset). The update covers the 37-bit value {address, word}, least significant bit first. A checksum write equal to the running value clears `crc_error` and zeroes the running value. A differing write sets `crc_error` and leaves the running value unchanged.
- R9: Read and no-op headers, and headers of any other type, consume no data words: the next word is a header.
- R10: After reset, `synced`, `fm_we`, `crc_error`, `id_mismatch` and `cmd_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| synced | output | 1 | Alignment marker found |
| fm_we | output | 1 | Frame memory write strobe |
| fm_addr | output | FAR_W+IDX_W | Frame memory word address |
| fm_wdata | output | 32 | Frame memory write data |
| cmd_value | output | CMD_W | Command register contents |
| crc_error | output | 1 | Last checksum write mismatched |
| id_mismatch | output | 1 | Last identity write mismatched |

## Verification
On every cycle the assertions check four things: `synced` never falls once set, nothing is written to frame memory or the command register before alignment, no frame write is issued while the identity flag reports a mismatch, and frame writes are never issued on back-to-back cycles. Other properties depend on the content of the stream, and only the bench scenarios show them: word counting and the long header's inherited target, the frame address sequence with its increment at each frame boundary, the CRC-32C values and the zeroing after a match, and the list of ignored addresses.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
    localparam logic [31:0] SYNC_MARK = 32'hAA995566;
    localparam int          ADDR_W    = 5;
    localparam int          CNT_W     = 27;

    localparam logic [2:0] PKT_SHORT = 3'b001;
    localparam logic [2:0] PKT_LONG  = 3'b010;

    localparam logic [1:0] OPC_NOP   = 2'b00;
    localparam logic [1:0] OPC_READ  = 2'b01;
    localparam logic [1:0] OPC_WRITE = 2'b10;

    localparam logic [ADDR_W-1:0] RA_CHK   = 5'd0;
    localparam logic [ADDR_W-1:0] RA_PTR   = 5'd1;
    localparam logic [ADDR_W-1:0] RA_FDATA = 5'd2;
    localparam logic [ADDR_W-1:0] RA_CMD   = 5'd4;
    localparam logic [ADDR_W-1:0] RA_IDENT = 5'd12;
    localparam logic [ADDR_W-1:0] RA_NONE  = 5'd31;

    localparam logic [31:0] CRC_POLY = 32'h82F63B78;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } reg_wr_t;

    typedef enum logic {M_HDR = 1'b0, M_DATA = 1'b1} pkt_mode_e;
endpackage

// File: rtl/cfgs_aligner.sv
module cfgs_aligner
    import cfgs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [7:0]  in_byte,
    output logic        synced,
    output logic        word_vld,
    output logic [31:0] word
);
    typedef struct packed {
        logic        synced;
        logic [31:0] shreg;
        logic [1:0]  bcnt;
        logic        wvld;
        logic [31:0] word;
    } al_t;

    al_t q, d;
    logic [31:0] window;

    always_comb begin
        d      = q;
        d.wvld = 1'b0;
        window = {q.shreg[23:0], in_byte};
        if (in_vld) begin
            d.shreg = window;
            if (!q.synced) begin
                if (window == SYNC_MARK) begin
                    d.synced = 1'b1;
                    d.bcnt   = 2'd0;
                end
            end else begin
                d.bcnt = q.bcnt + 2'd1;
                if (q.bcnt == 2'd3) begin
                    d.wvld = 1'b1;
                    d.word = window;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign synced   = q.synced;
    assign word_vld = q.wvld;
    assign word     = q.word;
endmodule

// File: rtl/cfgs_pkt_fsm.sv
module cfgs_pkt_fsm
    import cfgs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_vld,
    input  logic [31:0] word,
    output reg_wr_t     wr
);
    localparam int SHORT_CNT_W = 11;

    typedef struct packed {
        pkt_mode_e         mode;
        logic [CNT_W-1:0]  remain;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] last_short;
        reg_wr_t           wr;
    } fsm_t;

    fsm_t q, d;
    logic [2:0]             kind;
    logic [1:0]             opc;
    logic [ADDR_W-1:0]      hdr_addr;
    logic [SHORT_CNT_W-1:0] short_cnt;
    logic [CNT_W-1:0]       long_cnt;

    assign kind      = word[31:29];
    assign opc       = word[28:27];
    assign hdr_addr  = word[17:13];
    assign short_cnt = word[SHORT_CNT_W-1:0];
    assign long_cnt  = word[CNT_W-1:0];

    always_comb begin
        d        = q;
        d.wr.vld = 1'b0;
        if (word_vld) begin
            if (q.mode == M_HDR) begin
                case (kind)
                    PKT_SHORT: begin
                        d.last_short = hdr_addr;
                        if (opc == OPC_WRITE && short_cnt != '0) begin
                            d.mode   = M_DATA;
                            d.remain = CNT_W'(short_cnt);
                            d.tgt    = hdr_addr;
                        end
                    end
                    PKT_LONG: begin
                        if (opc == OPC_WRITE && long_cnt != '0) begin
                            d.mode   = M_DATA;
                            d.remain = long_cnt;
                            d.tgt    = q.last_short;
                        end
                    end
                    default: ;
                endcase
            end else begin
                d.wr.vld  = 1'b1;
                d.wr.addr = q.tgt;
                d.wr.data = word;
                d.remain  = q.remain - CNT_W'(1);
                if (q.remain == CNT_W'(1)) d.mode = M_HDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q            <= '0;
            q.last_short <= RA_NONE;
        end else begin
            q <= d;
        end
    end

    assign wr = q.wr;
endmodule

// File: rtl/cfgs_crc32c.sv
module cfgs_crc32c
    import cfgs_pkg::*;
(
    input  logic [31:0]       crc_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       data,
    output logic [31:0]       crc_out
);
    localparam int MSG_W = ADDR_W + 32;

    logic [MSG_W-1:0] msg;
    logic [31:0]      st [0:MSG_W];

    assign msg   = {addr, data};
    assign st[0] = crc_in;

    for (genvar g = 0; g < MSG_W; g++) begin : g_bit
        logic fb;
        assign fb        = st[g][0] ^ msg[g];
        assign st[g + 1] = {1'b0, st[g][31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end

    assign crc_out = st[MSG_W];
endmodule

// File: rtl/cfg_packet_engine.sv
module cfg_packet_engine
    import cfgs_pkg::*;
#(
    parameter logic [31:0] DEV_ID      = 32'h0A1B2C3D,
    parameter int          FAR_W       = 4,
    parameter int          FRAME_WORDS = 4,
    parameter int          CMD_W       = 5,
    localparam int         IDX_W       = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
    localparam int         FM_ADDR_W   = FAR_W + IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [7:0]           in_byte,
    output logic                 synced,
    output logic                 fm_we,
    output logic [FM_ADDR_W-1:0] fm_addr,
    output logic [31:0]          fm_wdata,
    output logic [CMD_W-1:0]     cmd_value,
    output logic                 crc_error,
    output logic                 id_mismatch
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_WORDS - 1);

    logic        word_vld;
    logic [31:0] word;
    reg_wr_t     wr;
    logic [31:0] crc_next;

    typedef struct packed {
        logic [CMD_W-1:0]     cmd;
        logic [FAR_W-1:0]     far;
        logic [IDX_W-1:0]     idx;
        logic                 id_ok;
        logic                 id_err;
        logic [31:0]          crc;
        logic                 crc_err;
        logic                 fm_we;
        logic [FM_ADDR_W-1:0] fm_addr;
        logic [31:0]          fm_data;
    } eng_t;

    eng_t q, d;

    cfgs_aligner u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_byte  (in_byte),
        .synced   (synced),
        .word_vld (word_vld),
        .word     (word)
    );

    cfgs_pkt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word     (word),
        .wr       (wr)
    );

    cfgs_crc32c u_crc (
        .crc_in  (q.crc),
        .addr    (wr.addr),
        .data    (wr.data),
        .crc_out (crc_next)
    );

    always_comb begin
        d       = q;
        d.fm_we = 1'b0;
        if (wr.vld) begin
            if (wr.addr != RA_CHK) d.crc = crc_next;
            case (wr.addr)
                RA_CHK: begin
                    if (wr.data == q.crc) begin
                        d.crc_err = 1'b0;
                        d.crc     = '0;
                    end else begin
                        d.crc_err = 1'b1;
                    end
                end
                RA_PTR: begin
                    d.far = wr.data[FAR_W-1:0];
                    d.idx = '0;
                end
                RA_FDATA: begin
                    if (q.id_ok) begin
                        d.fm_we   = 1'b1;
                        d.fm_addr = FM_ADDR_W'(q.far) * FM_ADDR_W'(FRAME_WORDS)
                                  + FM_ADDR_W'(q.idx);
                        d.fm_data = wr.data;
                        if (q.idx == IDX_LAST) begin
                            d.idx = '0;
                            d.far = q.far + FAR_W'(1);
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end
                end
                RA_CMD: d.cmd = wr.data[CMD_W-1:0];
                RA_IDENT: begin
                    d.id_ok  = (wr.data == DEV_ID);
                    d.id_err = (wr.data != DEV_ID);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fm_we       = q.fm_we;
    assign fm_addr     = q.fm_addr;
    assign fm_wdata    = q.fm_data;
    assign cmd_value   = q.cmd;
    assign crc_error   = q.crc_err;
    assign id_mismatch = q.id_err;
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
    parameter int CMD_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             synced,
    input logic             fm_we,
    input logic             id_mismatch,
    input logic [CMD_W-1:0] cmd_value
);
    a_r1_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> synced);

    a_r1_no_frame_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !fm_we);

    a_r1_cmd_hold_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |=> $stable(cmd_value));

    a_r7_no_frame_on_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
        fm_we |-> !id_mismatch);

    a_r2_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fm_we |=> !fm_we);
endmodule

bind cfg_packet_engine cfgs_checker #(.CMD_W(CMD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .synced      (synced),
    .fm_we       (fm_we),
    .id_mismatch (id_mismatch),
    .cmd_value   (cmd_value)
);

// File: tb/tb_cfg_packet_engine.sv
module tb_cfg_packet_engine;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] DEV_ID     = 32'h0A1B2C3D;
    localparam int          FAR_W      = 4;
    localparam int          FRAME_W    = 4;
    localparam int          CMD_W      = 5;
    localparam int          AW         = FAR_W + 2;
    localparam int          MEM_N      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          synced, fm_we, crc_error, id_mismatch;
    logic [AW-1:0] fm_addr;
    logic [31:0]   fm_wdata;
    logic [CMD_W-1:0] cmd_value;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    logic [31:0] fmem [0:MEM_N-1];
    logic [31:0] exp_crc = 32'h0;

    cfg_packet_engine #(.DEV_ID(DEV_ID), .FAR_W(FAR_W), .FRAME_WORDS(FRAME_W), .CMD_W(CMD_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .synced(synced), .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata),
        .cmd_value(cmd_value), .crc_error(crc_error), .id_mismatch(id_mismatch));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (fm_we) begin
            fmem[fm_addr] = fm_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [31:0] hdr_s(input logic [1:0] op, input logic [4:0] a, input int n);
        return {3'b001, op, 9'b0, a, 2'b0, 11'(n)};
    endfunction

    function automatic logic [31:0] hdr_l(input logic [1:0] op, input int n);
        return {3'b010, op, 27'(n)};
    endfunction

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [4:0] a, input logic [31:0] w);
        logic [63:0] m;
        logic [31:0] r;
        m = {27'b0, a, w};
        r = c;
        for (int i = 0; i < 37; i++) begin
            if ((r[0] ^ m[i]) == 1'b1) r = (r >> 1) ^ 32'h82F63B78;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_vld  = 1'b1;
        in_byte = b;
        @(negedge clk);
        in_vld  = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8]);
    endtask

    task automatic data_word(input logic [4:0] a, input logic [31:0] w);
        send_word(w);
        if (a != 5'd0) exp_crc = crc_ref(exp_crc, a, w);
    endtask

    task automatic wr1(input logic [4:0] a, input logic [31:0] w);
        send_word(hdr_s(2'b10, a, 1));
        data_word(a, w);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_crc = 32'h0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cnt0;
        @(negedge clk);
        do_reset();
        // R10 reset state
        check(synced == 0 && fm_we == 0, "R10", {30'b0, synced, fm_we}, 32'h0);
        check(cmd_value == 0 && crc_error == 0 && id_mismatch == 0, "R10",
              {27'b0, cmd_value} | {crc_error, id_mismatch, 30'b0}, 32'h0);

        // R1: a command write before the marker has no effect
        send_word(hdr_s(2'b10, 5'd4, 1));
        send_word(32'h0000001B);
        settle();
        check(synced == 0, "R1", {31'b0, synced}, 32'h0);
        check(cmd_value == 0, "R1", {27'b0, cmd_value}, 32'h0);
        // odd offset before marker
        send_byte(8'h12); send_byte(8'hAA); send_byte(8'h99);
        send_word(32'hAA995566);
        settle();
        check(synced == 1, "R1", {31'b0, synced}, 32'h1);

        // R2/R3/R5: command sweep
        for (int v = 0; v < 32; v++) begin
            wr1(5'd4, 32'hABCD0000 | v);
            settle();
            check(cmd_value == CMD_W'(v), "R3", {27'b0, cmd_value}, v);
        end

        // R3: zero count header goes straight to next header
        send_word(hdr_s(2'b10, 5'd4, 0));
        wr1(5'd4, 32'h15);
        settle();
        check(cmd_value == 5'h15, "R3", {27'b0, cmd_value}, 32'h15);

        // R9: read and no-op consume no data
        send_word(hdr_s(2'b01, 5'd4, 3));
        send_word(hdr_s(2'b00, 5'd4, 2));
        send_word(32'hE0000005);
        wr1(5'd4, 32'h0A);
        settle();
        check(cmd_value == 5'h0A, "R9", {27'b0, cmd_value}, 32'h0A);

        // R7: frame data dropped before identity
        wr1(5'd1, 32'h2);
        cnt0 = wr_cnt;
        wr1(5'd2, 32'h55);
        settle();
        check(wr_cnt == cnt0, "R7", wr_cnt, cnt0);
        wr1(5'd12, DEV_ID ^ 32'h1);
        settle();
        check(id_mismatch == 1, "R7", {31'b0, id_mismatch}, 32'h1);
        wr1(5'd2, 32'h56);
        settle();
        check(wr_cnt == cnt0, "R7", wr_cnt, cnt0);
        wr1(5'd12, DEV_ID);
        settle();
        check(id_mismatch == 0, "R7", {31'b0, id_mismatch}, 32'h0);

        // R5: undecoded addresses ignored
        wr1(5'd1, 32'h3);
        cnt0 = wr_cnt;
        for (int a = 0; a < 32; a++) begin
            if (a != 0 && a != 1 && a != 2 && a != 4 && a != 12) begin
                wr1(5'(a), 32'h1F);
                settle();
                check(cmd_value == 5'h0A && wr_cnt == cnt0, "R5", {27'b0, cmd_value}, 32'h0A);
            end
        end

        // R4/R6: long packet to frame data after zero-count short header
        for (int i = 0; i < MEM_N; i++) fmem[i] = 32'h0;
        send_word(hdr_s(2'b10, 5'd2, 0));
        send_word(hdr_l(2'b10, 10));
        for (int i = 0; i < 10; i++) data_word(5'd2, 32'hC0DE0000 + i);
        settle();
        check(wr_cnt == cnt0 + 10, "R4", wr_cnt, cnt0 + 10);
        for (int i = 0; i < 10; i++)
            check(fmem[12 + i] == 32'hC0DE0000 + i, "R6", fmem[12 + i], 32'hC0DE0000 + i);
        check(fmem[11] == 0 && fmem[22] == 0, "R6", fmem[11] | fmem[22], 32'h0);

        // R8: checksum compare
        wr1(5'd0, exp_crc);
        settle();
        check(crc_error == 0, "R8", {31'b0, crc_error}, 32'h0);
        exp_crc = 32'h0;
        wr1(5'd4, 32'h3);
        wr1(5'd0, exp_crc ^ 32'h1);
        settle();
        check(crc_error == 1, "R8", {31'b0, crc_error}, 32'h1);
        wr1(5'd0, exp_crc);
        settle();
        check(crc_error == 0, "R8", {31'b0, crc_error}, 32'h0);
        exp_crc = 32'h0;
        wr1(5'd4, 32'h7);
        wr1(5'd0, exp_crc);
        settle();
        check(crc_error == 0, "R8", {31'b0, crc_error}, 32'h0);

        // R4: long header with no prior short header targets nothing
        do_reset();
        check(synced == 0 && cmd_value == 0, "R10", {27'b0, cmd_value}, 32'h0);
        send_word(32'hAA995566);
        cnt0 = wr_cnt;
        send_word(hdr_l(2'b10, 3));
        send_word(32'h11); send_word(32'h12); send_word(32'h13);
        settle();
        check(cmd_value == 0 && wr_cnt == cnt0, "R4", {27'b0, cmd_value}, 32'h0);
        wr1(5'd4, 32'h9);
        settle();
        check(cmd_value == 5'h9, "R4", {27'b0, cmd_value}, 32'h9);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule